// File: doc/BRIEF.md
# Packed SIMD Saturating Adder-Subtractor

This unit treats each of two 64-bit operand words as a row of equal-width integer lanes (eight 8-bit, four 16-bit, two 32-bit or one 64-bit lane) and applies one operation to every pair of matching lanes at once. The operation is an add, a subtract, an equality compare or a signed greater-than compare. For add and subtract, a mode selects how each lane handles results that do not fit. Wraparound keeps the low bits. Signed saturation clamps to the signed range of the lane. Unsigned saturation clamps to the unsigned range.

A caller presents both operands and a 6-bit opcode with a valid strobe. One clock later the registered 64-bit result appears with its own valid flag. Compares return a mask per lane, all ones for true and all zeros for false. The unit reports no carry, overflow or other status. The only extra output flags an opcode that asks for saturation on a lane width that has no saturating form.

Top module: `simd_addsub`

## Requirements
- R1: The opcode bits [5:4] select the operation (0 add, 1 subtract, 2 equal compare, 3 signed greater-than compare). Bits [3:2] select the lane width (0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit). Bits [1:0] select the mode (0 wraparound, 1 signed saturation, 2 unsigned saturation, 3 reserved). Lane i occupies bits [i*W+W-1 : i*W], and every lane is computed independently.
- R2: In wraparound mode an add or subtract keeps the W low bits of each lane and drops the carry or borrow. For example, bytes 154 + 205 give 103. Wraparound is legal at every lane width.
- R3: In signed saturation mode, a lane result is clamped to -128..127 for 8-bit lanes and to -32768..32767 for 16-bit lanes.
- R4: In unsigned saturation mode, a lane result is clamped to 0..255 for 8-bit lanes and to 0..65535 for 16-bit lanes. A subtraction that falls below zero yields 0.
- R5: An equal compare sets each lane to all ones when the two lanes are identical and to all zeros otherwise. Mode bits are ignored.
- R6: A greater-than compare sets each lane to all ones when the first operand's lane, read as signed, exceeds the second's, and to all zeros otherwise. Mode bits are ignored.
- R7: An add or subtract that uses mode 3, or that uses mode 1 or 2 with 32-bit or 64-bit lanes, is illegal. It produces a zero result, and `out_illegal` is high for that one output cycle only.
- R8: `out_valid` in a cycle equals `in_valid` of the previous cycle. The result of an accepted operation appears exactly one cycle after it is presented.
- R9: While `in_valid` is low, `result` keeps its previous value.
- R10: A synchronous active-high `rst` clears `result`, `out_valid` and `out_illegal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation presented this cycle |
| opcode | input | 6 | Operation, lane width and mode fields |
| op_a | input | 64 | First packed operand |
| op_b | input | 64 | Second packed operand |
| out_valid | output | 1 | Registered result is fresh |
| out_illegal | output | 1 | Registered operation was an illegal combination |
| result | output | 64 | Registered packed result |

## Verification
The hardest behaviour to reach from the ports is a saturation clamp on a single lane whose neighbours do not clamp, in each direction and for both signed and unsigned readings of the same bits. Random operands almost never land exactly on a boundary such as 0x7F + 0x01 or 0x8000 - 1. The directed vectors therefore place boundary values in chosen lanes and ordinary values in the others, so that a clamp leaking across a lane boundary shows up. Random traffic over all 64 opcodes, mixed with idle cycles, then covers the legal and illegal combinations and the hold behaviour against a behavioural model.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [1:0] {K_ADD = 2'd0, K_SUB = 2'd1, K_EQ = 2'd2, K_GT = 2'd3} kind_e;
  typedef enum logic [1:0] {LW_8 = 2'd0, LW_16 = 2'd1, LW_32 = 2'd2, LW_64 = 2'd3} lanew_e;
  typedef enum logic [1:0] {M_WRAP = 2'd0, M_SSAT = 2'd1, M_USAT = 2'd2, M_RSVD = 2'd3} mode_e;

  typedef struct packed {
    kind_e  kind;
    lanew_e lanew;
    mode_e  mode;
  } opcode_t;

  localparam int unsigned OPC_W      = $bits(opcode_t);
  localparam int unsigned NUM_WIDTHS = 4;
endpackage

// File: rtl/simd_lane.sv
module simd_lane
  import simd_pkg::*;
#(
  parameter int unsigned LW = 8
) (
  input  logic [LW-1:0] a,
  input  logic [LW-1:0] b,
  input  kind_e         kind,
  input  mode_e         mode,
  output logic [LW-1:0] res,
  output logic          clamped
);
  localparam int unsigned XW = LW + 1;

  function automatic logic [LW-1:0] clamp_signed(input logic [XW-1:0] s);
    if (s[XW-1] != s[XW-2]) begin
      clamp_signed = s[XW-1] ? {1'b1, {(LW-1){1'b0}}} : {1'b0, {(LW-1){1'b1}}};
    end else begin
      clamp_signed = s[LW-1:0];
    end
  endfunction

  function automatic logic [LW-1:0] clamp_unsigned(input logic [XW-1:0] u, input logic is_sub);
    if (u[XW-1]) begin
      clamp_unsigned = is_sub ? {LW{1'b0}} : {LW{1'b1}};
    end else begin
      clamp_unsigned = u[LW-1:0];
    end
  endfunction

  logic            is_sub;
  logic [XW-1:0]   u_sum;
  logic [XW-1:0]   s_sum;
  logic            u_out;
  logic            s_out;

  always_comb begin
    is_sub = (kind == K_SUB);
    u_sum  = is_sub ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
    s_sum  = is_sub ? ({a[LW-1], a} - {b[LW-1], b}) : ({a[LW-1], a} + {b[LW-1], b});
    u_out  = u_sum[XW-1];
    s_out  = s_sum[XW-1] ^ s_sum[XW-2];
  end

  always_comb begin
    clamped = 1'b0;
    unique case (kind)
      K_EQ: res = {LW{a == b}};
      K_GT: res = {LW{$signed(a) > $signed(b)}};
      default: begin
        unique case (mode)
          M_SSAT: begin
            res     = clamp_signed(s_sum);
            clamped = s_out;
          end
          M_USAT: begin
            res     = clamp_unsigned(u_sum, is_sub);
            clamped = u_out;
          end
          default: res = u_sum[LW-1:0];
        endcase
      end
    endcase
  end
endmodule

// File: rtl/simd_width_slice.sv
module simd_width_slice
  import simd_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned LW     = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  kind_e             kind,
  input  mode_e             mode,
  output logic [DATA_W-1:0] res,
  output logic              any_clamp
);
  localparam int unsigned LANES = DATA_W / LW;

  logic [LANES-1:0] lane_clamp;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    simd_lane #(.LW(LW)) u_lane (
      .a       (a[i*LW +: LW]),
      .b       (b[i*LW +: LW]),
      .kind    (kind),
      .mode    (mode),
      .res     (res[i*LW +: LW]),
      .clamped (lane_clamp[i])
    );
  end

  assign any_clamp = |lane_clamp;
endmodule

// File: rtl/simd_op_check.sv
module simd_op_check
  import simd_pkg::*;
(
  input  opcode_t op,
  output logic    illegal
);
  logic arith;
  logic sat_mode;
  logic wide_lane;

  always_comb begin
    arith     = (op.kind == K_ADD) || (op.kind == K_SUB);
    sat_mode  = (op.mode == M_SSAT) || (op.mode == M_USAT);
    wide_lane = (op.lanew == LW_32) || (op.lanew == LW_64);
    illegal   = arith && ((op.mode == M_RSVD) || (sat_mode && wide_lane));
  end
endmodule

// File: rtl/simd_addsub.sv
module simd_addsub
  import simd_pkg::*;
#(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned LANE_MIN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic              out_valid,
  output logic              out_illegal,
  output logic [DATA_W-1:0] result
);
  opcode_t           op;
  logic [DATA_W-1:0] slice_res [NUM_WIDTHS];
  logic [NUM_WIDTHS-1:0] slice_clamp;
  logic              op_illegal;
  logic              sat_event;
  logic [DATA_W-1:0] next_result;

  assign op = opcode_t'(opcode);

  for (genvar w = 0; w < NUM_WIDTHS; w++) begin : g_width
    simd_width_slice #(.DATA_W(DATA_W), .LW(LANE_MIN << w)) u_slice (
      .a         (op_a),
      .b         (op_b),
      .kind      (op.kind),
      .mode      (op.mode),
      .res       (slice_res[w]),
      .any_clamp (slice_clamp[w])
    );
  end

  simd_op_check u_check (
    .op      (op),
    .illegal (op_illegal)
  );

  always_comb begin
    sat_event   = slice_clamp[op.lanew] && !op_illegal;
    next_result = op_illegal ? '0 : slice_res[op.lanew];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      result      <= '0;
    end else begin
      out_valid   <= in_valid;
      out_illegal <= in_valid && op_illegal;
      if (in_valid) begin
        result <= next_result;
      end
    end
  end
endmodule

// File: rtl/simd_addsub_chk.sv
module simd_addsub_chk #(
  parameter int unsigned DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [5:0]        opcode,
  input logic              out_valid,
  input logic              out_illegal,
  input logic [DATA_W-1:0] result,
  input logic              op_illegal,
  input logic              sat_event
);
  logic mask_ok;
  logic is_cmp;
  logic is_wrap_arith;

  always_comb begin
    mask_ok = 1'b1;
    for (int i = 0; i < DATA_W / 8; i++) begin
      if (result[i*8 +: 8] != 8'h00 && result[i*8 +: 8] != 8'hFF) mask_ok = 1'b0;
    end
    is_cmp        = opcode[5];
    is_wrap_arith = !opcode[5] && (opcode[1:0] == 2'd0);
  end

  p_valid_rise_r8: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid);
  p_valid_drop_r8: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid);
  p_hold_r9: assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(result));
  p_illegal_zero_r7: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> (out_valid && result == '0));
  p_illegal_pulse_r7: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_illegal);
  p_illegal_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_illegal) |=> out_illegal);
  p_cmp_mask_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_cmp) |=> mask_ok);
  p_wrap_noclamp_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_wrap_arith) |-> !sat_event);
  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_illegal && result == '0));
endmodule

bind simd_addsub simd_addsub_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .opcode      (opcode),
  .out_valid   (out_valid),
  .out_illegal (out_illegal),
  .result      (result),
  .op_illegal  (op_illegal),
  .sat_event   (sat_event)
);

// File: tb/test_simd_addsub.sv
module test_simd_addsub;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [5:0]  opcode = '0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic        out_valid;
  logic        out_illegal;
  logic [63:0] result;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [63:0] exp_res = '0;
  logic        exp_valid = 1'b0;
  logic        exp_ill = 1'b0;
  string       exp_tag = "R10";

  always #4 clk = ~clk;

  simd_addsub i_simd_addsub (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid),
    .out_illegal(out_illegal), .result(result)
  );

  function automatic logic [5:0] mk(int kind, int w, int m);
    return {kind[1:0], w[1:0], m[1:0]};
  endfunction

  function automatic void model(input logic [63:0] a, input logic [63:0] b,
                                input logic [5:0] op, output logic [63:0] r,
                                output logic ill);
    int kind = int'(op[5:4]);
    int w    = int'(op[3:2]);
    int m    = int'(op[1:0]);
    int lw   = 8 << w;
    logic [63:0] msk = (lw == 64) ? '1 : ((64'd1 << lw) - 64'd1);
    r   = '0;
    ill = (kind < 2) && (m == 3 || (m != 0 && w >= 2));
    if (ill) return;
    for (int i = 0; i < 64 / lw; i++) begin
      logic [63:0] ua = (a >> (i * lw)) & msk;
      logic [63:0] ub = (b >> (i * lw)) & msk;
      longint sa = $signed(ua << (64 - lw)) >>> (64 - lw);
      longint sb = $signed(ub << (64 - lw)) >>> (64 - lw);
      longint t;
      logic [63:0] v;
      if (kind == 2) v = (ua == ub) ? msk : '0;
      else if (kind == 3) v = (sa > sb) ? msk : '0;
      else if (m == 0) v = (kind == 1) ? (ua - ub) : (ua + ub);
      else if (m == 1) begin
        t = (kind == 1) ? (sa - sb) : (sa + sb);
        if (t > (64'sd1 <<< (lw - 1)) - 1) t = (64'sd1 <<< (lw - 1)) - 1;
        if (t < -(64'sd1 <<< (lw - 1))) t = -(64'sd1 <<< (lw - 1));
        v = t;
      end else begin
        t = (kind == 1) ? (longint'(ua) - longint'(ub)) : (longint'(ua) + longint'(ub));
        if (t < 0) t = 0;
        if (t > longint'(msk)) t = longint'(msk);
        v = t;
      end
      r = r | ((v & msk) << (i * lw));
    end
  endfunction

  task automatic step(input logic [63:0] a, input logic [63:0] b, input logic [5:0] op,
                      input logic v, input logic r, input string tag);
    logic [63:0] nr;
    logic        ni;
    @(negedge clk);
    n_checks++;
    if (result !== exp_res || out_valid !== exp_valid || out_illegal !== exp_ill) begin
      n_fail++;
      $display("FAIL %s: got res=%h v=%b ill=%b exp res=%h v=%b ill=%b",
               exp_tag, result, out_valid, out_illegal, exp_res, exp_valid, exp_ill);
    end
    rst = r; in_valid = v; opcode = op; op_a = a; op_b = b;
    model(a, b, op, nr, ni);
    if (r) begin
      exp_res = '0; exp_valid = 1'b0; exp_ill = 1'b0;
    end else begin
      exp_valid = v;
      exp_ill   = v && ni;
      if (v) exp_res = nr;
    end
    exp_tag = tag;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R10: reset state checked on the first step
    step('0, '0, '0, 1'b0, 1'b0, "R10");
    step({8{8'h9A}}, {8{8'hCD}}, mk(0, 0, 0), 1, 0, "R2");
    step(64'h0000_0000_0000_0001, 64'h0000_0000_0000_0002, mk(1, 0, 0), 1, 0, "R2");
    step(64'hFFFF_FFFF_0000_0001, 64'h0000_0001_FFFF_FFFF, mk(0, 2, 0), 1, 0, "R1");
    step(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0002, mk(0, 3, 0), 1, 0, "R1");
    step(64'h0110_2280_7F7F_8001, 64'h0101_01FF_0101_FF01, mk(0, 0, 1), 1, 0, "R3");
    step(64'h8000_7FFF_0005_1234, 64'h0001_FFFF_0003_0034, mk(1, 1, 1), 1, 0, "R3");
    step(64'h7FFF_8000_0100_0000, 64'h0001_0001_0100_0000, mk(0, 1, 1), 1, 0, "R3");
    step(64'h1020_3040_FF00_8010, 64'h2010_4030_0101_7F20, mk(1, 0, 2), 1, 0, "R4");
    step(64'hFFFF_0001_8000_1234, 64'h0001_0001_8000_0000, mk(0, 1, 2), 1, 0, "R4");
    step(64'h1234_5678_9ABC_DEF0, 64'h1234_0000_9ABC_1111, mk(2, 1, 3), 1, 0, "R5");
    step(64'h807F_0001_FF00_7F80, 64'h7F80_0100_00FF_7F7F, mk(3, 0, 2), 1, 0, "R6");
    step(64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, mk(3, 3, 0), 1, 0, "R6");
    step(64'h1, 64'h2, mk(0, 2, 1), 1, 0, "R7");
    step(64'h5, 64'h6, mk(1, 3, 2), 1, 0, "R7");
    step(64'h7, 64'h8, mk(0, 0, 3), 1, 0, "R7");
    step(64'h7, 64'h8, mk(0, 0, 0), 0, 0, "R7");
    step(64'hDEAD, 64'hBEEF, mk(0, 0, 0), 0, 0, "R9");
    step(64'h1111, 64'h2222, mk(0, 1, 0), 1, 0, "R8");
    step(64'h3333, 64'h4444, mk(1, 1, 0), 1, 1, "R10");
    step('0, '0, '0, 0, 0, "R10");
    for (int k = 0; k < 400; k++) begin
      logic [63:0] ra = {$urandom, $urandom};
      logic [63:0] rb = (k % 5 == 0) ? ra : {$urandom, $urandom};
      logic [5:0]  ro = 6'($urandom);
      step(ra, rb, ro, ($urandom % 4) != 0, 0, "R1");
    end
    step('0, '0, '0, 0, 0, "R9");
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule